// File: doc/BRIEF.md
# Asynchronous SRAM Transaction Sequencer

This block sits between a synchronous host and an external asynchronous static RAM with a 16-bit data path, per-byte enables and a single-bit-corrected error flag. The host offers one transaction at a time through a ready/valid handshake: an address, a direction bit, write data and two byte strobes. The block then produces the memory's active-low select, output-enable, write-enable and byte-enable pins, drives or releases the data bus, and for reads returns the captured data word together with the memory's error flag under a one-cycle valid pulse.

Every phase length is a whole number of clock cycles. It is computed at elaboration from the clock period parameter and the memory's minimum timing numbers, rounded up, and it is never less than one cycle. A read passes through a select phase, an output-enabled phase and a recovery phase. A write passes through a turnaround phase with the bus released, a write-strobe phase with data driven, and a recovery phase. The output enable stays high for the whole of a write, so the bus-release interval only has to cover a preceding read.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted, select, output enable and write enable are high, both byte enables are high (value 2'b11), the bus drive enable is low, reqReady is high and respValid is low.
- R2: reqReady is high exactly in the idle cycles. A request is taken at the rising edge where reqValid and reqReady are both high. A request held during a transaction is not taken until the block is idle again.
- R3: A read selects the memory with output enable high for 1 cycle. It then holds output enable low for max(ceil(tAA/CLK_NS), ceil(tOE/CLK_NS)) cycles, and then stays selected with output enable high for max(1, ceil(tRC/CLK_NS) - 1 - active) recovery cycles.
- R4: Read data and the error flag are sampled at the edge that ends the output-enabled phase. respValid is high for exactly the first recovery cycle. respData and respErr keep their values until the next read capture.
- R5: A data lane whose byte strobe was 0 in the read request returns zero in respData (bit 0 of the strobe selects bits 7:0, bit 1 selects bits 15:8).
- R6: A write selects the memory with write enable high and the bus released for max(1, ceil(tHZ/CLK_NS)) cycles. It then holds write enable low for max(ceil(tPWE/CLK_NS), ceil(tSD/CLK_NS)) cycles, and then stays selected with write enable high for max(1, ceil(tWC/CLK_NS) - setup - active) cycles.
- R7: The bus drive enable is high only during the write-enable-low phase and the write recovery phase. It is never high while output enable is low.
- R8: From acceptance to the end of the transaction, the memory address, the byte enables (the inverse of the request strobes) and the driven write data stay at the values of the request.
- R9: Output enable and write enable are never low in the same cycle.
- R10: Two consecutive acceptances are at least ceil(tRC/CLK_NS) cycles apart. With a request held continuously, the next one is taken in the idle cycle right after recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqBe | input | DATA_W/8 | Byte strobes, bit i selects lane i |
| respValid | output | 1 | One-cycle pulse with read result |
| respData | output | DATA_W | Captured read data, disabled lanes zero |
| respErr | output | 1 | Captured memory error flag |
| memAddr | output | ADDR_W | Memory address pins |
| memCsN | output | 1 | Chip select, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memBeN | output | DATA_W/8 | Byte enables, active low |
| memDqOut | output | DATA_W | Data to drive on the bus |
| memDqOe | output | 1 | Bus drive enable |
| memDqIn | input | DATA_W | Data read from the bus |
| memErr | input | 1 | Memory corrected-error flag |

## Verification
A phase counter that is loaded with a wrong count, or a state register that takes a wrong branch, makes the select, enable or drive pins differ from the expected cycle trace in the very first cycle where that phase should end. The bench compares every pin on every clock, so such faults show within one cycle. The bench memory model also returns a poison word and a set error flag when a read is sampled before the address and output enable have been held long enough, so a read phase that is too short shows as wrong data at the response pulse. A write whose strobes or bus drive are misplaced shows as a mismatch when the same location is read back later.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD_SET,
    PH_RD_ACT,
    PH_WR_SET,
    PH_WR_ACT,
    PH_REC
  } phase_e;

  // Strobes from control to datapath, taken from the next phase
  typedef struct packed {
    logic take;   // request accepted this edge
    logic sel;    // memory selected next cycle
    logic oe;     // output enable next cycle
    logic we;     // write enable next cycle
    logic drive;  // bus driven next cycle
    logic grab;   // capture read data this edge
  } strobe_t;

  function automatic int cycFor(int ns, int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int CLK_NS = 10,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_OE   = 25,
  parameter int T_WC   = 55,
  parameter int T_PWE  = 40,
  parameter int T_SD   = 25,
  parameter int T_HZ   = 18
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t strb
);

  localparam int RD_SET_C = 1;
  localparam int RD_ACT_C = maxOf(cycFor(T_AA, CLK_NS), cycFor(T_OE, CLK_NS));
  localparam int RD_REC_C = maxOf(1, cycFor(T_RC, CLK_NS) - RD_SET_C - RD_ACT_C);
  localparam int WR_SET_C = cycFor(T_HZ, CLK_NS);
  localparam int WR_ACT_C = maxOf(cycFor(T_PWE, CLK_NS), cycFor(T_SD, CLK_NS));
  localparam int WR_REC_C = maxOf(1, cycFor(T_WC, CLK_NS) - WR_SET_C - WR_ACT_C);
  localparam int MAX_C    = maxOf(maxOf(maxOf(RD_SET_C, RD_ACT_C), maxOf(RD_REC_C, WR_SET_C)),
                                  maxOf(WR_ACT_C, WR_REC_C));
  localparam int CNT_W    = $clog2(MAX_C + 1);
  localparam int RC_C     = cycFor(T_RC, CLK_NS);
  localparam int GAP_W    = $clog2(RC_C + 1);

  localparam logic [CNT_W-1:0] LD_RD_SET = CNT_W'(RD_SET_C);
  localparam logic [CNT_W-1:0] LD_RD_ACT = CNT_W'(RD_ACT_C);
  localparam logic [CNT_W-1:0] LD_RD_REC = CNT_W'(RD_REC_C);
  localparam logic [CNT_W-1:0] LD_WR_SET = CNT_W'(WR_SET_C);
  localparam logic [CNT_W-1:0] LD_WR_ACT = CNT_W'(WR_ACT_C);
  localparam logic [CNT_W-1:0] LD_WR_REC = CNT_W'(WR_REC_C);

  phase_e           state, nxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             isWr;
  logic             lastCyc;
  logic             take;

  assign lastCyc  = (cnt == CNT_W'(1));
  assign reqReady = (state == PH_IDLE);
  assign take     = (state == PH_IDLE) && reqValid;

  always_comb begin
    nxt    = state;
    cntNxt = cnt - CNT_W'(1);
    case (state)
      PH_IDLE: begin
        cntNxt = cnt;
        if (reqValid) begin
          nxt    = reqWrite ? PH_WR_SET : PH_RD_SET;
          cntNxt = reqWrite ? LD_WR_SET : LD_RD_SET;
        end
      end
      PH_RD_SET: if (lastCyc) begin nxt = PH_RD_ACT; cntNxt = LD_RD_ACT; end
      PH_RD_ACT: if (lastCyc) begin nxt = PH_REC;    cntNxt = LD_RD_REC; end
      PH_WR_SET: if (lastCyc) begin nxt = PH_WR_ACT; cntNxt = LD_WR_ACT; end
      PH_WR_ACT: if (lastCyc) begin nxt = PH_REC;    cntNxt = LD_WR_REC; end
      PH_REC:    if (lastCyc) begin nxt = PH_IDLE;   cntNxt = '0; end
      default: begin nxt = PH_IDLE; cntNxt = '0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= PH_IDLE;
      cnt   <= '0;
      isWr  <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= cntNxt;
      if (take) isWr <= reqWrite;
    end
  end

  always_comb begin
    strb.take  = take;
    strb.sel   = (nxt != PH_IDLE);
    strb.oe    = (nxt == PH_RD_ACT);
    strb.we    = (nxt == PH_WR_ACT);
    strb.drive = (nxt == PH_WR_ACT) || (nxt == PH_REC && (isWr || state == PH_WR_ACT));
    strb.grab  = (state == PH_RD_ACT) && lastCyc;
  end

  // Cycles since the last acceptance, saturating at the read cycle time
  logic [GAP_W-1:0] sinceTake;
  always_ff @(posedge clk) begin
    if (!rstN)                    sinceTake <= GAP_W'(RC_C);
    else if (take)                sinceTake <= GAP_W'(1);
    else if (sinceTake < GAP_W'(RC_C)) sinceTake <= sinceTake + GAP_W'(1);
  end

  AST_CYCLE_TIME: assert property (@(posedge clk) disable iff (!rstN)
    take |-> (sinceTake >= GAP_W'(RC_C))); // R10

  AST_PHASE_LOADED: assert property (@(posedge clk) disable iff (!rstN)
    (state != PH_IDLE) |-> (cnt != '0)); // R3

  AST_REC_FROM_ACT: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(state == PH_REC)) |-> ($past(state) == PH_RD_ACT || $past(state) == PH_WR_ACT)); // R6

endmodule

// File: rtl/asram_ctrl_dp.sv
module asram_ctrl_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W-1:0]     reqWdata,
  input  logic [DATA_W/8-1:0]   reqBe,
  input  logic [DATA_W-1:0]     memDqIn,
  input  logic                  memErr,
  output logic [ADDR_W-1:0]     memAddr,
  output logic                  memCsN,
  output logic                  memWeN,
  output logic                  memOeN,
  output logic [DATA_W/8-1:0]   memBeN,
  output logic [DATA_W-1:0]     memDqOut,
  output logic                  memDqOe,
  output logic                  respValid,
  output logic [DATA_W-1:0]     respData,
  output logic                  respErr
);

  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] laneMask;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneMask[i*8 +: 8] = {8{~memBeN[i]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr   <= '0;
      memCsN    <= 1'b1;
      memWeN    <= 1'b1;
      memOeN    <= 1'b1;
      memBeN    <= '1;
      memDqOut  <= '0;
      memDqOe   <= 1'b0;
      respValid <= 1'b0;
      respData  <= '0;
      respErr   <= 1'b0;
    end else begin
      memCsN    <= ~strb.sel;
      memOeN    <= ~strb.oe;
      memWeN    <= ~strb.we;
      memDqOe   <= strb.drive;
      respValid <= strb.grab;
      if (strb.take) begin
        memAddr  <= reqAddr;
        memDqOut <= reqWdata;
        memBeN   <= ~reqBe;
      end else if (!strb.sel) begin
        memBeN   <= '1;
      end
      if (strb.grab) begin
        respData <= memDqIn & laneMask;
        respErr  <= memErr;
      end
    end
  end

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN)); // R9

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (memOeN && !memCsN)); // R7

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && !$past(memCsN)) |-> ($stable(memAddr) && $stable(memBeN))); // R8

  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe && $past(memDqOe)) |-> $stable(memDqOut)); // R8

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid); // R4

  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!respValid && $past(!respValid)) |-> ($stable(respData) && $stable(respErr))); // R4

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int CLK_NS = 10,
  parameter int T_RC   = 55,
  parameter int T_AA   = 55,
  parameter int T_OE   = 25,
  parameter int T_WC   = 55,
  parameter int T_PWE  = 40,
  parameter int T_SD   = 25,
  parameter int T_HZ   = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqBe,
  output logic                respValid,
  output logic [DATA_W-1:0]   respData,
  output logic                respErr,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memCsN,
  output logic                memWeN,
  output logic                memOeN,
  output logic [DATA_W/8-1:0] memBeN,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  input  logic [DATA_W-1:0]   memDqIn,
  input  logic                memErr
);

  strobe_t strb;

  asram_ctrl_fsm #(
    .CLK_NS(CLK_NS), .T_RC(T_RC), .T_AA(T_AA), .T_OE(T_OE),
    .T_WC(T_WC), .T_PWE(T_PWE), .T_SD(T_SD), .T_HZ(T_HZ)
  ) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqReady (reqReady),
    .strb     (strb)
  );

  asram_ctrl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .reqWdata  (reqWdata),
    .reqBe     (reqBe),
    .memDqIn   (memDqIn),
    .memErr    (memErr),
    .memAddr   (memAddr),
    .memCsN    (memCsN),
    .memWeN    (memWeN),
    .memOeN    (memOeN),
    .memBeN    (memBeN),
    .memDqOut  (memDqOut),
    .memDqOe   (memDqOe),
    .respValid (respValid),
    .respData  (respData),
    .respErr   (respErr)
  );

endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int AW = 21;
  localparam int DW = 16;

  function automatic int cdiv(int ns);
    int c;
    c = (ns + 9) / 10;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // Phase lengths from the requirements, CLK_NS = 10
  localparam int RD_SET = 1;
  localparam int RD_ACT = (cdiv(55) > cdiv(25)) ? cdiv(55) : cdiv(25);
  localparam int RD_REC = (cdiv(55) - RD_SET - RD_ACT > 1) ? cdiv(55) - RD_SET - RD_ACT : 1;
  localparam int WR_SET = cdiv(18);
  localparam int WR_ACT = (cdiv(40) > cdiv(25)) ? cdiv(40) : cdiv(25);
  localparam int WR_REC = (cdiv(55) - WR_SET - WR_ACT > 1) ? cdiv(55) - WR_SET - WR_ACT : 1;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid, reqReady, reqWrite;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] reqWdata;
  logic [1:0]    reqBe;
  logic          respValid, respErr;
  logic [DW-1:0] respData;
  logic [AW-1:0] memAddr;
  logic          memCsN, memWeN, memOeN, memDqOe, memErr;
  logic [1:0]    memBeN;
  logic [DW-1:0] memDqOut, memDqIn;

  always #5 clk = ~clk;

  asram_ctrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .respValid(respValid), .respData(respData), .respErr(respErr),
    .memAddr(memAddr), .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN),
    .memBeN(memBeN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn), .memErr(memErr)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit running = 0;
  int lastAccept = -1;
  int gap = 0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] mem [int];
  int addrAge = 0;
  int oeAge = 0;
  logic [AW-1:0] lastAddr = '0;

  function automatic logic [DW-1:0] memRd(logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[15:0] ^ 16'h5A5A;
  endfunction
  function automatic logic errBit(logic [AW-1:0] a);
    return (a % 7) == 3;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memCsN)                 addrAge <= 0;
    else if (memAddr != lastAddr) addrAge <= 1;
    else                        addrAge <= addrAge + 1;
    lastAddr <= memAddr;
    oeAge <= memOeN ? 0 : oeAge + 1;
  end

  logic rdOk;
  always @(*) begin
    rdOk = !memCsN && !memOeN && (addrAge + 1 >= RD_SET + RD_ACT) && (oeAge + 1 >= cdiv(25));
    if (rdOk) begin
      memDqIn[7:0]  = memBeN[0] ? 8'hEE : memRd(memAddr) [7:0];
      memDqIn[15:8] = memBeN[1] ? 8'hEE : memRd(memAddr) [15:8];
      memErr = errBit(memAddr);
    end else begin
      memDqIn = 16'hBAD0;
      memErr  = 1'b1;
    end
  end

  always @(posedge memWeN) begin
    if (rstN === 1'b1 && memCsN === 1'b0) begin
      logic [DW-1:0] w;
      w = memRd(memAddr);
      if (!memBeN[0]) w[7:0]  = memDqOut[7:0];
      if (!memBeN[1]) w[15:8] = memDqOut[15:8];
      mem[int'(memAddr)] = w;
      check("R7", "bus driven at write end", {31'd0, memDqOe}, 32'd1);
    end
  end

  // ---------------- expected pin trace ----------------
  typedef struct packed {
    logic          wr, csN, oeN, weN, drv, ready, resp, err;
    logic [AW-1:0] addr;
    logic [1:0]    beN;
    logic [DW-1:0] data;
  } exp_t;

  exp_t expQ[$];

  function automatic exp_t idleE();
    exp_t e;
    e = '0;
    e.csN = 1; e.oeN = 1; e.weN = 1; e.ready = 1; e.beN = 2'b11;
    return e;
  endfunction

  always @(negedge clk) begin
    if (running) begin
      exp_t e;
      string tag;
      e = (expQ.size() > 0) ? expQ.pop_front() : idleE();
      tag = e.wr ? "R6" : "R3";
      check(tag,  "memCsN", {31'd0, memCsN}, {31'd0, e.csN});
      check(tag,  "memOeN", {31'd0, memOeN}, {31'd0, e.oeN});
      check(tag,  "memWeN", {31'd0, memWeN}, {31'd0, e.weN});
      check("R7", "memDqOe", {31'd0, memDqOe}, {31'd0, e.drv});
      check("R2", "reqReady", {31'd0, reqReady}, {31'd0, e.ready});
      check("R4", "respValid", {31'd0, respValid}, {31'd0, e.resp});
      check("R9", "oe/we overlap", {31'd0, (!memWeN && !memOeN)}, 32'd0);
      if (!e.csN) begin
        check("R8", "memAddr", {11'd0, memAddr}, {11'd0, e.addr});
        check("R8", "memBeN", {30'd0, memBeN}, {30'd0, e.beN});
      end
      if (e.drv) check("R8", "memDqOut", {16'd0, memDqOut}, {16'd0, e.data});
      if (e.resp) begin
        check("R4", "respData", {16'd0, respData}, {16'd0, e.data});
        check("R4", "respErr", {31'd0, respErr}, {31'd0, e.err});
      end
    end
  end

  // ---------------- request driver ----------------
  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d, logic [1:0] be);
    exp_t e;
    logic [DW-1:0] rd;
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    gap = (lastAccept < 0) ? 0 : cyc - lastAccept;
    lastAccept = cyc;
    e = '0;
    e.wr = wr; e.addr = a; e.beN = ~be; e.ready = 0;
    if (wr) begin
      e.data = d;
      for (int i = 0; i < WR_SET; i++) begin e.csN=0; e.oeN=1; e.weN=1; e.drv=0; expQ.push_back(e); end
      for (int i = 0; i < WR_ACT; i++) begin e.csN=0; e.oeN=1; e.weN=0; e.drv=1; expQ.push_back(e); end
      for (int i = 0; i < WR_REC; i++) begin e.csN=0; e.oeN=1; e.weN=1; e.drv=1; expQ.push_back(e); end
    end else begin
      rd = memRd(a);
      if (!be[0]) rd[7:0]  = 8'h00;
      if (!be[1]) rd[15:8] = 8'h00;
      e.data = rd; e.err = errBit(a);
      for (int i = 0; i < RD_SET; i++) begin e.csN=0; e.oeN=1; e.weN=1; e.drv=0; expQ.push_back(e); end
      for (int i = 0; i < RD_ACT; i++) begin e.csN=0; e.oeN=0; e.weN=1; e.drv=0; expQ.push_back(e); end
      for (int i = 0; i < RD_REC; i++) begin
        e.csN=0; e.oeN=1; e.weN=1; e.drv=0; e.resp = (i == 0);
        expQ.push_back(e);
      end
    end
    @(negedge clk);
  endtask

  task automatic quiet(int n);
    reqValid = 0;
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rstN = 0; reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0; reqBe = 2'b00;
    repeat (3) @(negedge clk);
    check("R1", "reset memCsN", {31'd0, memCsN}, 32'd1);
    check("R1", "reset memOeN", {31'd0, memOeN}, 32'd1);
    check("R1", "reset memWeN", {31'd0, memWeN}, 32'd1);
    check("R1", "reset memBeN", {30'd0, memBeN}, 32'd3);
    check("R1", "reset memDqOe", {31'd0, memDqOe}, 32'd0);
    check("R1", "reset reqReady", {31'd0, reqReady}, 32'd1);
    check("R1", "reset respValid", {31'd0, respValid}, 32'd0);
    rstN = 1;
    @(negedge clk);
    running = 1;
    quiet(2);

    // R3 R4: read of untouched location, both lanes
    issue(0, 21'h00010, 16'h0, 2'b11); quiet(12);
    // R6: full write then read back
    issue(1, 21'h00010, 16'h1234, 2'b11); quiet(12);
    issue(0, 21'h00010, 16'h0, 2'b11); quiet(12);
    // R6 R8: low lane write only
    issue(1, 21'h00010, 16'hABCD, 2'b01); quiet(12);
    issue(0, 21'h00010, 16'h0, 2'b11); quiet(12);
    check("R6", "partial write merge", {16'd0, respData}, 32'h12CD);
    // R5: single-lane reads zero the other lane
    issue(0, 21'h00010, 16'h0, 2'b10); quiet(12);
    check("R5", "upper lane only", {16'd0, respData}, 32'h1200);
    issue(0, 21'h00010, 16'h0, 2'b01); quiet(12);
    check("R5", "lower lane only", {16'd0, respData}, 32'h00CD);
    // R4: error flag captured with data (address 3 mod 7 flags)
    issue(0, 21'h00003, 16'h0, 2'b11); quiet(12);
    check("R4", "error flag held", {31'd0, respErr}, 32'd1);
    // R2 R10: requests held back to back
    issue(1, 21'h00020, 16'hC0DE, 2'b11);
    issue(0, 21'h00020, 16'h0, 2'b11);
    check("R10", "write-to-read acceptance gap", gap, WR_SET + WR_ACT + WR_REC + 1);
    issue(0, 21'h1FFFFF, 16'h0, 2'b11);
    check("R10", "read-to-read acceptance gap", gap, RD_SET + RD_ACT + RD_REC + 1);
    issue(1, 21'h1FFFFF, 16'h7777, 2'b00);
    check("R10", "read-to-write acceptance gap", gap, RD_SET + RD_ACT + RD_REC + 1);
    quiet(12);
    // R8: write with no strobes leaves memory unchanged
    issue(0, 21'h1FFFFF, 16'h0, 2'b11); quiet(12);
    check("R8", "no-strobe write ignored", {16'd0, respData}, {16'd0, 16'h5A5A ^ 16'hFFFF});
    check("R2", "queue drained", expQ.size(), 0);

    running = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule